// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

The block drives the four coil lines of a unipolar stepper motor. A fast system clock runs it. An internal prescaler divides that clock into a slow step tick. On each tick the block looks at two direction request lines. It moves a phase index one place forward, one place back, or leaves it where it is. It then drives the coil pattern for the new index from one of two tables, selected by a mode input:

- An eight-entry half-step table.
- A four-entry table with a single coil energised at a time (wave drive).

The coil lines are registered, so they do not glitch. The current phase index is available as a status output. After reset the block is idle: the index is 0 and all coils are off, until the first step is taken. A step taken from the idle state uses the normal index movement. A forward step therefore lands on entry 1, and a reverse step lands on the last entry.

Top module: `stepper_phase_seq`

## Requirements
- R1: A synchronous active-low reset sets `phase_o` to 0 and `coils_o` to 4'b0000. Both stay at those values, even on ticks where neither request or both requests are high, until a step is taken.
- R2: The prescaler produces one tick every `TICK_DIV` system clocks (`TICK_DIV` ≥ 2). After reset is released, the outputs can change only at clock edge `TICK_DIV`+1 and at every `TICK_DIV` edges after that. They never change at any other edge.
- R3: When `mode_half_i` = 1, forward steps drive `coils_o` (bit 3 first) through 1000, 1100, 0100, 0110, 0010, 0011, 0001, 1001 for index values 0 to 7.
- R4: When `mode_half_i` = 0, forward steps drive `coils_o` through 1000, 0100, 0010, 0001 for index values 0 to 3.
- R5: A tick with `rev_i` = 1 and `fwd_i` = 0 moves the index back by one. From index 0 it goes to the last entry of the active table: 7 in half-step mode, 3 in wave mode.
- R6: A tick with `fwd_i` = 1 and `rev_i` = 0 moves the index forward by one. From the last entry it goes to index 0.
- R7: A tick with both requests high, or both low, leaves `phase_o` and `coils_o` unchanged.
- R8: A step uses the mode value present on its tick. Before the move, the stored index is reduced modulo the length of the new table. For example, index 6 followed by a wave-mode forward step gives index 3 (0001).
- R9: `phase_o` shows the stored index. After any step taken in wave mode, it is below 4.
- R10: `coils_o` never has more than two bits set. After a step in wave mode, exactly one bit is set.
- R11: Request levels are sampled only on the tick. A request pulse that starts and ends between ticks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_half_i | input | 1 | 1 selects the half-step table, 0 selects the wave table |
| fwd_i | input | 1 | Forward step request |
| rev_i | input | 1 | Reverse step request |
| coils_o | output | 4 | Registered coil drive, bit 3 is the first coil |
| phase_o | output | 3 | Current phase index |

## Verification
The bench checks the wrap in both directions in both tables. A design with an off-by-one table bound would show an undefined pattern, or skip 1001 and 0001. It switches mode while the index is above 3. A design that did not reduce the index would leave the coils at a pattern from the wrong table, or at 0000. It drives both requests together, and drives a short request pulse between ticks. A design with a wrong priority would step when it should hold. A design that sampled requests on every clock would step on the pulse. It also checks that the coils stay at 0000 through the whole first interval after reset. A design that started moving one cycle early would energise the coils before that interval ends.

// File: rtl/stepper_pkg.sv
// Shared constants and the coil table lookup for the stepper sequencer.
// Assumes four coil lines and an index wide enough for the half-step table.
package stepper_pkg;

    localparam int IDX_W    = 3;
    localparam int COIL_W   = 4;
    localparam int HALF_LEN = 8;
    localparam int WAVE_LEN = 4;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [COIL_W-1:0] coil_t;

    // Coil pattern for an index in the selected table; bit 3 is the first coil.
    function automatic coil_t coil_pattern(input logic half, input idx_t idx);
        coil_t p;
        if (half) begin
            // even entries energise one coil, odd entries a coil and its successor
            p = coil_t'(4'b1000 >> idx[IDX_W-1:1]);
            if (idx[0])
                p = p | ((idx[IDX_W-1:1] == 2'd3) ? 4'b1000 : (p >> 1));
        end else begin
            p = coil_t'(4'b1000 >> idx[1:0]);
        end
        return p;
    endfunction

endpackage

// File: rtl/step_tick_gen.sv
// Prescaler: emits a one-clock tick once every TICK_DIV system clocks.
// Assumes TICK_DIV >= 2, so a tick is never followed by another tick.
module step_tick_gen #(
    parameter int TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    initial begin
        a_r2_div_min: assert (TICK_DIV >= 2);
    end

    // Count the interval and pulse the tick on its last clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/phase_stepper.sv
// Phase index state: on a tick, moves the index one entry in the requested
// direction, with wrap, inside the active table. Assumes both table lengths are
// powers of two, so that reducing to the wave table keeps only the low bits.
module phase_stepper
    import stepper_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic mode_half_i,
    input  logic fwd_i,
    input  logic rev_i,
    output logic step_o,
    output idx_t idx_nxt_o,
    output idx_t idx_o
);
    localparam idx_t HALF_TOP = idx_t'(HALF_LEN - 1);
    localparam idx_t WAVE_TOP = idx_t'(WAVE_LEN - 1);

    idx_t top;
    idx_t reduced;

    // Decide whether this tick steps, and compute the next index.
    always_comb begin
        top       = mode_half_i ? HALF_TOP : WAVE_TOP;
        reduced   = idx_o & top;
        step_o    = tick_i && (fwd_i != rev_i);
        idx_nxt_o = idx_o;
        if (fwd_i && !rev_i)
            idx_nxt_o = (reduced == top) ? '0 : reduced + 1'b1;
        else if (rev_i && !fwd_i)
            idx_nxt_o = (reduced == '0) ? top : reduced - 1'b1;
    end

    // Hold the index, and take the new value only on a stepping tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_o <= '0;
        else if (step_o)
            idx_o <= idx_nxt_o;
    end

    a_r7_hold_index: assert property (@(posedge clk) disable iff (!rst_n)
        !step_o |=> $stable(idx_o));
    a_r9_wave_range: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && !mode_half_i) |=> (idx_o < idx_t'(WAVE_LEN)));

endmodule

// File: rtl/coil_driver.sv
// Registered coil outputs: load the table pattern for the new index on each step
// and hold it otherwise. Reset clears all coils (idle state).
module coil_driver
    import stepper_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step_i,
    input  logic  mode_half_i,
    input  idx_t  idx_i,
    output coil_t coils_o
);
    // Load the coil register from the table when a step is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            coils_o <= '0;
        else if (step_i)
            coils_o <= coil_pattern(mode_half_i, idx_i);
    end

    a_r10_max_two: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(coils_o) <= 2);
    a_r10_wave_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !mode_half_i) |=> ($countones(coils_o) == 1));

endmodule

// File: rtl/stepper_phase_seq.sv
// Top of the stepper phase sequencer: prescaler, index stepper and coil register.
// Assumes the request and mode inputs are synchronous to clk.
module stepper_phase_seq #(
    parameter int TICK_DIV = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_half_i,
    input  logic       fwd_i,
    input  logic       rev_i,
    output logic [3:0] coils_o,
    output logic [2:0] phase_o
);
    import stepper_pkg::*;

    logic tick;
    logic step;
    idx_t idx_nxt;
    idx_t idx_q;

    step_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    phase_stepper u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .mode_half_i (mode_half_i),
        .fwd_i       (fwd_i),
        .rev_i       (rev_i),
        .step_o      (step),
        .idx_nxt_o   (idx_nxt),
        .idx_o       (idx_q)
    );

    coil_driver u_coils (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step),
        .mode_half_i (mode_half_i),
        .idx_i       (idx_nxt),
        .coils_o     (coils_o)
    );

    assign phase_o = idx_q;

    a_r2_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(coils_o) && $stable(phase_o)));
    a_r11_no_step_between: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> !step);

endmodule

// File: tb/stepper_phase_seq_test.sv
module stepper_phase_seq_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_half = 1'b1;
    logic       fwd = 1'b0;
    logic       rev = 1'b0;
    logic [3:0] coils;
    logic [2:0] phase;

    int n_run = 0;
    int n_fail = 0;
    int exp_idx = 0;
    logic [3:0] exp_coil = 4'b0000;

    always #4 clk = ~clk;

    stepper_phase_seq #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .mode_half_i(mode_half),
        .fwd_i(fwd), .rev_i(rev), .coils_o(coils), .phase_o(phase)
    );

    function automatic logic [3:0] tbl(input logic half, input int i);
        logic [3:0] h [8] = '{4'b1000, 4'b1100, 4'b0100, 4'b0110,
                              4'b0010, 4'b0011, 4'b0001, 4'b1001};
        logic [3:0] w [4] = '{4'b1000, 4'b0100, 4'b0010, 4'b0001};
        return half ? h[i] : w[i % 4];
    endfunction

    task automatic check(input string req, input logic [3:0] got_c, input int got_p);
        n_run++;
        if (got_c !== exp_coil || got_p != exp_idx) begin
            n_fail++;
            $display("FAIL %s: coils=%b phase=%0d expected coils=%b phase=%0d",
                     req, got_c, got_p, exp_coil, exp_idx);
        end
        n_run++;
        if ($countones(got_c) > 2 || (!mode_half && exp_coil != 0 && $countones(got_c) != 1)) begin
            n_fail++;
            $display("FAIL R10: coils=%b expected one coil in wave, at most two", got_c);
        end
    endtask

    // Model of one tick with the given requests.
    task automatic model(input logic f, input logic r, input logic m);
        int len = m ? 8 : 4;
        int red = exp_idx % len;
        if (f && !r) exp_idx = (red == len - 1) ? 0 : red + 1;
        else if (r && !f) exp_idx = (red == 0) ? len - 1 : red - 1;
        if (f != r) exp_coil = tbl(m, exp_idx);
    endtask

    // One step interval with steady inputs, sampled after the update edge.
    task automatic do_step(input logic f, input logic r, input logic m, input string req);
        fwd = f; rev = r; mode_half = m;
        repeat (DIV) @(posedge clk);
        @(negedge clk);
        model(f, r, m);
        check(req, coils, int'(phase));
    endtask

    // Reset, then verify idle and the first interval timing with one step.
    task automatic reset_and_start(input logic f, input logic r, input logic m, input string req);
        @(negedge clk);
        rst_n = 0; fwd = 0; rev = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_idx = 0; exp_coil = 4'b0000;
        check("R1 reset state", coils, int'(phase));
        rst_n = 1; fwd = f; rev = r; mode_half = m;
        repeat (DIV) @(posedge clk);
        @(negedge clk);
        check("R2 no change before first tick", coils, int'(phase));
        @(posedge clk);
        @(negedge clk);
        model(f, r, m);
        check(req, coils, int'(phase));
    endtask

    task automatic t_half_forward();
        reset_and_start(1, 0, 1, "R2 first step at edge DIV+1");
        for (int k = 0; k < 8; k++) do_step(1, 0, 1, "R3 R6 half forward");
    endtask

    task automatic t_hold();
        do_step(1, 1, 1, "R7 both requests hold");
        do_step(0, 0, 1, "R7 no request hold");
    endtask

    task automatic t_half_reverse();
        for (int k = 0; k < 9; k++) do_step(0, 1, 1, "R5 half reverse wrap");
    endtask

    task automatic t_mode_switch();
        while (exp_idx != 6) do_step(1, 0, 1, "R3 position");
        do_step(1, 0, 0, "R8 switch to wave forward from 6");
        for (int k = 0; k < 5; k++) do_step(1, 0, 0, "R4 R6 wave forward");
        for (int k = 0; k < 5; k++) do_step(0, 1, 0, "R5 R9 wave reverse");
        do_step(1, 0, 1, "R8 back to half");
    endtask

    task automatic t_pulse();
        @(negedge clk);
        fwd = 1; rev = 0;
        @(posedge clk);
        @(negedge clk);
        fwd = 0;
        check("R11 mid-interval", coils, int'(phase));
        repeat (DIV - 1) @(posedge clk);
        @(negedge clk);
        check("R11 pulse between ticks ignored", coils, int'(phase));
    endtask

    task automatic t_reset_idle_then_reverse();
        reset_and_start(0, 0, 1, "R1 idle hold with no request");
        do_step(1, 1, 1, "R1 idle hold with both requests");
        do_step(0, 1, 1, "R5 reverse from idle to last");
        reset_and_start(0, 1, 0, "R5 R9 wave reverse from idle to 3");
    endtask

    initial begin
        t_half_forward();
        t_hold();
        t_half_reverse();
        t_mode_switch();
        t_pulse();
        t_reset_idle_then_reverse();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule